// File: doc/BRIEF.md
# Queued-Sample Pulse-Width Modulator

This block generates a single pulse-width modulated output whose high time is taken from a short queue of duty samples. Software sets a period value and pushes duty samples through a register-style write port. The generator removes one sample from the queue at each period boundary, so a push never changes the period that is already running. Once the queue runs dry, the generator keeps using the last duty it applied.

The read port returns three values: the stored period, the sample the generator is using or will use next, and a status word with the queue occupancy and a sticky overflow flag. Because a read returns the next sample to be used, a write followed at once by a read can give back an older value than the one just written. The counter advances only in cycles where the tick enable is high, and the prescaler is fixed at one.

Register addresses are 0 for the period, 1 for the sample and 2 for the status word.

Top module: `qpwm_gen`

## Requirements
- R1: A write to address 0 stores the period value P. A write of 0xFFFF is stored as 0xFFFE. A read of address 0 returns the stored value.
- R2: While running, each period lasts P+2 counting ticks, with the count going from 0 to P+1 and then wrapping. The output is high for the first min(D, P+2) ticks, where D is the active duty. With D = 0 the output stays low for the whole period.
- R3: The queue holds 4 samples and a write to address 1 pushes one. A push while the queue is full is dropped and sets the sticky overflow flag, which is status bit 3. Writing address 2 with bit 3 set clears the flag.
- R4: Status bits [2:0] give the number of queued samples, from 0 to 4. The value 0 means the queue is empty. All other status bits read 0.
- R5: A push while running does not change the current period. At each wrap, one sample is popped from a non-empty queue and becomes the active duty for the next period.
- R6: A read of address 1 while running returns the queue head if the queue is non-empty, and the active duty otherwise. While not running it returns 0.
- R7: Once the queue is empty, every following period repeats the last active duty.
- R8: When run_en goes high, the generator runs from the next cycle with the count at 0. If the queue holds a sample, that sample is popped in the same step and becomes the active duty. If the queue is empty, the previous active duty is kept.
- R9: When run_en goes low, the output is low from the next cycle and the queue is emptied. Pushes made while stopped are kept until the next start.
- R10: While tick enable is low, the count and the output stay frozen. Counting resumes from the same point when tick enable returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Counting tick enable |
| run_en | input | 1 | Generator enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 period, 1 sample, 2 status) |
| wr_data | input | DW (16) | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | DW (16) | Read data, combinational from rd_addr |
| pwm_out | output | 1 | PWM output |

## Verification
A wrong queue pointer or count appears on the status word as soon as the next push or pop happens. A pop at the wrong time shows on the output as a period of the wrong width within one period, which is P+2 cycles. A period with the wrong length or a wrong compare changes the number of high cycles counted in every measured window, so the bench sweeps every duty from 0 to past P+2 for several small periods. A freeze, a missed flush or a lost hold of the active duty shows in the first window after a stop, a restart or a stretch with tick enable low.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;
   localparam int QP_AW = 2;
   typedef enum logic [QP_AW-1:0] {
      QP_PERIOD = 2'd0,
      QP_SAMPLE = 2'd1,
      QP_STATUS = 2'd2
   } qp_reg_e;
endpackage

// File: rtl/qpwm_queue.sv
module qpwm_queue #(
   parameter int DW    = 16,
   parameter int DEPTH = 4,
   localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNTW = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic [DW-1:0]   push_data,
   input  logic            pop,
   input  logic            flush,
   output logic [DW-1:0]   head,
   output logic [CNTW-1:0] count,
   output logic            drop
);
   logic [DW-1:0]   mem [DEPTH];
   logic [PTRW-1:0] wptr, rptr;
   logic            full, accept, take;

   assign full   = (count == CNTW'(DEPTH));
   assign accept = push && !full && !flush;
   assign drop   = push && full && !flush;
   assign take   = pop && (count != '0) && !flush;
   assign head   = mem[rptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (accept) begin
            mem[wptr] <= push_data;
            wptr      <= wptr + PTRW'(1);
         end
         if (take) rptr <= rptr + PTRW'(1);
         case ({accept, take})
            2'b10:   count <= count + CNTW'(1);
            2'b01:   count <= count - CNTW'(1);
            default: count <= count;
         endcase
      end
   end

   assert_count_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNTW'(DEPTH));
   assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> (count == CNTW'(DEPTH)));
   assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0));
endmodule

// File: rtl/qpwm_timer.sv
module qpwm_timer #(
   parameter int DW      = 16,
   parameter bit OUT_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          running,
   input  logic          live,
   input  logic          start,
   input  logic [DW-1:0] period,
   input  logic          q_avail,
   input  logic [DW-1:0] q_head,
   output logic          pop,
   output logic [DW-1:0] active,
   output logic          pwm
);
   logic [DW-1:0] cnt, lim;
   logic          adv, wrap, level;

   assign lim   = period + DW'(1);
   assign wrap  = (cnt >= lim);
   assign adv   = live && tick;
   assign pop   = q_avail && (start || (adv && wrap));
   assign level = running && (cnt < active);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         active <= '0;
      end else if (start) begin
         cnt <= '0;
         if (q_avail) active <= q_head;
      end else if (adv) begin
         if (wrap) begin
            cnt <= '0;
            if (q_avail) active <= q_head;
         end else begin
            cnt <= cnt + DW'(1);
         end
      end
   end

   generate
      if (OUT_REG) begin : g_out_reg
         logic pwm_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pwm_q <= 1'b0;
            else        pwm_q <= level;
         end
         assign pwm = pwm_q;
      end else begin : g_out_comb
         assign pwm = level;
      end
   endgenerate

   assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && wrap && !start) |=> (cnt == '0));
   assert_duty_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !start && !(adv && wrap)) |=> $stable(active));
   assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !tick && !start) |=> $stable(cnt));
endmodule

// File: rtl/qpwm_gen.sv
module qpwm_gen
   import qpwm_pkg::*;
#(
   parameter int DW      = 16,
   parameter int DEPTH   = 4,
   parameter bit OUT_REG = 1'b0,
   localparam int CNTW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_en,
   input  logic             run_en,
   input  logic             wr_en,
   input  logic [QP_AW-1:0] wr_addr,
   input  logic [DW-1:0]    wr_data,
   input  logic [QP_AW-1:0] rd_addr,
   output logic [DW-1:0]    rd_data,
   output logic             pwm_out
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("qpwm_gen: DEPTH must be a power of two of at least 2");
      end
      if (DW < CNTW + 2) begin : g_bad_width
         $error("qpwm_gen: DW too narrow for the status word");
      end
   endgenerate

   localparam logic [DW-1:0] PMAX = {{(DW-1){1'b1}}, 1'b0};

   logic            running, start, stop, live;
   logic [DW-1:0]   period_q, head, active;
   logic [CNTW-1:0] count;
   logic            ovf, drop, pop, push, clr_ovf;

   assign start   = run_en && !running;
   assign stop    = !run_en && running;
   assign live    = run_en && running;
   assign push    = wr_en && (wr_addr == QP_SAMPLE);
   assign clr_ovf = wr_en && (wr_addr == QP_STATUS) && wr_data[CNTW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running  <= 1'b0;
         period_q <= '0;
         ovf      <= 1'b0;
      end else begin
         running <= run_en;
         if (wr_en && (wr_addr == QP_PERIOD))
            period_q <= (wr_data == {DW{1'b1}}) ? PMAX : wr_data;
         if (drop)         ovf <= 1'b1;
         else if (clr_ovf) ovf <= 1'b0;
      end
   end

   qpwm_queue #(.DW(DW), .DEPTH(DEPTH)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (wr_data),
      .pop       (pop),
      .flush     (stop),
      .head      (head),
      .count     (count),
      .drop      (drop)
   );

   qpwm_timer #(.DW(DW), .OUT_REG(OUT_REG)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (clk_en),
      .running (running),
      .live    (live),
      .start   (start),
      .period  (period_q),
      .q_avail (count != '0),
      .q_head  (head),
      .pop     (pop),
      .active  (active),
      .pwm     (pwm_out)
   );

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         QP_PERIOD: rd_data = period_q;
         QP_SAMPLE: rd_data = running ? ((count != '0) ? head : active) : '0;
         QP_STATUS: rd_data = {{(DW-CNTW-1){1'b0}}, ovf, count};
         default:   rd_data = '0;
      endcase
   end

   assert_period_clamp_R1: assert property (@(posedge clk) disable iff (!rst_n)
      period_q != {DW{1'b1}});
   assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr_ovf) |=> ovf);
   assert_stop_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !OUT_REG) |=> !pwm_out);
endmodule

// File: tb/tb_qpwm_gen.sv
`timescale 1ns/1ps
module tb_qpwm_gen;
   localparam int DW = 16;

   logic          clk = 1'b0, rst_n = 1'b0, clk_en = 1'b1, run_en = 1'b0, wr_en = 1'b0;
   logic [1:0]    wr_addr = '0, rd_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          pwm_out;

   int  checks = 0, failures = 0, hi_tot = 0;
   bit  done = 1'b0;

   qpwm_gen dut (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .run_en(run_en),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
   );

   always #5 clk = ~clk;
   always @(posedge clk) hi_tot <= hi_tot + int'(pwm_out);

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
      end
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input int d);
      wr_addr = a; wr_data = DW'(d); wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      rd_addr = a;
      #1;
      v = int'(rd_data);
   endtask

   task automatic window(input int n, output int hi);
      int s;
      s = hi_tot;
      waitc(n);
      hi = hi_tot - s;
   endtask

   task automatic go();
      run_en = 1'b1;
      waitc(1);
   endtask

   task automatic halt();
      run_en = 1'b0;
      waitc(1);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int v, hi;
      waitc(3);
      rst_n = 1'b1;
      waitc(1);

      chk("R9 reset output low", int'(pwm_out), 0);
      rd(2'd2, v); chk("R4 reset status", v, 0);
      rd(2'd1, v); chk("R6 reset sample", v, 0);
      rd(2'd0, v); chk("R1 reset period", v, 0);

      wr(2'd0, 16'hFFFF); rd(2'd0, v); chk("R1 clamp 0xFFFF", v, 16'hFFFE);
      wr(2'd0, 4);        rd(2'd0, v); chk("R1 period 4", v, 4);

      wr(2'd1, 1); wr(2'd1, 3); wr(2'd1, 5); wr(2'd1, 2);
      rd(2'd2, v); chk("R4 four queued", v, 4);
      rd(2'd1, v); chk("R6 stopped sample reads 0", v, 0);
      wr(2'd1, 7);
      rd(2'd2, v); chk("R3 overflow flag set", v, 12);
      wr(2'd2, 0);
      rd(2'd2, v); chk("R3 write 0 keeps flag", v, 12);
      wr(2'd2, 8);
      rd(2'd2, v); chk("R3 overflow flag cleared", v, 4);

      go();
      rd(2'd2, v); chk("R8 first sample popped on start", v, 3);
      rd(2'd1, v); chk("R6 read returns next sample", v, 3);
      window(6, hi); chk("R8 first period duty", hi, 1);
      window(6, hi); chk("R5 second period duty", hi, 3);
      window(6, hi); chk("R5 third period duty", hi, 5);
      rd(2'd2, v); chk("R4 empty after drain", v, 0);
      window(6, hi); chk("R5 fourth period duty", hi, 2);
      window(6, hi); chk("R7 last duty held", hi, 2);
      rd(2'd1, v); chk("R6 empty queue reads active", v, 2);

      begin
         int s;
         s = hi_tot;
         wr(2'd1, 0);
         waitc(5);
         chk("R5 mid-period push no effect", hi_tot - s, 2);
      end
      window(6, hi); chk("R2 duty zero all low", hi, 0);
      wr(2'd1, 4); wr(2'd1, 6);
      rd(2'd1, v); chk("R6 read gives head not last write", v, 4);
      rd(2'd2, v); chk("R4 two queued", v, 2);
      halt();
      rd(2'd2, v); chk("R9 queue flushed on stop", v, 0);
      rd(2'd1, v); chk("R6 sample reads 0 after stop", v, 0);

      wr(2'd1, 9);
      go();
      waitc(2);
      chk("R2 duty above period stays high", int'(pwm_out), 1);
      wr(2'd1, 3);
      halt();
      chk("R9 output low after stop", int'(pwm_out), 0);
      rd(2'd2, v); chk("R9 flush with pending sample", v, 0);

      go();
      window(6, hi); chk("R8 empty start keeps active duty", hi, 6);
      wr(2'd1, 3);
      waitc(5);
      clk_en = 1'b0;
      window(20, hi); chk("R10 frozen with tick low", hi, 20);
      clk_en = 1'b1;
      window(6, hi); chk("R10 resumes after freeze", hi, 3);

      for (int p = 0; p < 4; p++) begin
         for (int d = 0; d <= p + 3; d++) begin
            int e;
            e = (d < p + 2) ? d : p + 2;
            halt();
            wr(2'd0, p);
            wr(2'd1, d);
            go();
            window(p + 2, hi); chk($sformatf("R2 sweep p=%0d d=%0d", p, d), hi, e);
            window(p + 2, hi); chk($sformatf("R7 sweep hold p=%0d d=%0d", p, d), hi, e);
         end
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule